// File: doc/BRIEF.md
# Touch Controller Register Bus Slave

This block is the host-facing side of a multi-key capacitive touch controller. It is a slave on a two-wire, I2C-compatible bus. It answers only its own fixed 7-bit address. It holds a byte-wide register pointer and gives access to a byte-addressed map. The map holds identification bytes, live status bytes taken from the sensing core, read-only per-key 16-bit reference values, a bank of writable configuration bytes, and two command locations. A nonzero write to a command location starts a calibration or a device reset.

A write transaction places the first byte after the address into the pointer. Each later byte goes to the pointed location, and the pointer advances after every byte. A read transaction has no pointer phase. It streams bytes from wherever the pointer was left, so a host can poll the same registers again and again without re-addressing. The master ends a read with a NACK and then a STOP.

Both bus lines are brought into the block's clock domain through synchronisers. SDA is driven only low, through an output enable. The block does not stretch the clock and does not take part in arbitration. An active-low change line tells the host that new status is waiting. It goes low a set time after reset and again whenever the key status input changes. It returns high once the host reads a status byte.

Top module: `touch_i2c_regs`

## Requirements
- R1: Only a first byte whose upper seven bits equal 0x1B is acknowledged. For any other address the block leaves SDA released for the rest of the transaction.
- R2: In a write, the byte after the address byte loads the pointer. Every following byte is stored at the pointed location, and every byte is acknowledged.
- R3: A read transaction returns bytes from the pointer value left by the previous transaction, with no pointer phase. The pointer persists across STOP.
- R4: The pointer advances by one after every data byte read or written, and wraps from 255 to 0.
- R5: After the master NACKs a read byte, the block releases SDA and accepts the next START.
- R6: Address 0 reads 0x2E and address 1 reads 0x15. Address 2 reads the flags input and address 3 reads the key status input. Addresses 18+2k and 19+2k read the high and low byte of key k's reference. Writes to addresses 0 to 31 are acknowledged and have no effect.
- R7: Addresses 32 to 55 are read/write bytes that read zero after reset.
- R8: Writing a nonzero byte to address 56 produces exactly one single-cycle `cal_req_o` pulse. Writing zero produces none. Address 56 reads zero.
- R9: Writing a nonzero byte to address 57 produces one single-cycle `rst_req_o` pulse. It also clears addresses 32 to 55 to zero and restarts the change delay with the change line high.
- R10: `chg_n_o` is high after reset and goes low CHG_DLY cycles later. After that delay it also goes low whenever the key status input changes. It returns high when the host reads address 2 or 3.
- R11: The SDA output enable changes only while the synchronised SCL is low. An SDA edge while SCL is high is decoded as START (falling) or STOP (rising), including a repeated START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| flags_i | input | 8 | General status flags from the sensing core |
| keys_i | input | 8 | Per-key detection status from the sensing core |
| refs_i | input | NKEYS*16 | Reference values, key k in bits [16k+15:16k] |
| cal_req_o | output | 1 | One-cycle calibration request |
| rst_req_o | output | 1 | One-cycle device reset request |
| chg_n_o | output | 1 | Active-low change notification |

## Verification
The bench builds the block with NKEYS=7, a two-stage synchroniser and CHG_DLY=2000. The short delay lets the change line's power-up expiry, release, re-trigger and restart after a soft reset all happen inside a few thousand cycles. With seven keys the reference region ends exactly at address 31, so the edge between read-only references and writable configuration can be probed at both sides. The 8-bit pointer is also driven to 255, which exercises the wrap to the identification byte.

// File: rtl/touch_i2c_pkg.sv
package touch_i2c_pkg;
  localparam logic [7:0] ID_CODE  = 8'h2E;
  localparam logic [7:0] REV_CODE = 8'h15;
  localparam logic [7:0] A_ID     = 8'd0;
  localparam logic [7:0] A_REV    = 8'd1;
  localparam logic [7:0] A_FLAGS  = 8'd2;
  localparam logic [7:0] A_KEYS   = 8'd3;
  localparam logic [7:0] A_REF    = 8'd18;
  localparam logic [7:0] A_CFG    = 8'd32;
  localparam logic [7:0] A_CFGEND = 8'd55;
  localparam logic [7:0] A_CAL    = 8'd56;
  localparam logic [7:0] A_RST    = 8'd57;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK} eng_state_t;
  typedef enum logic [1:0] {K_DEV, K_PTR, K_DATA} byte_kind_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_p    <= scl_pipe[STAGES-1];
      sda_p    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
  import touch_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h1B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic       sda_oe,
  output logic       wr_en,
  output logic       rd_en,
  output logic [7:0] acc_addr,
  output logic [7:0] wr_data,
  output logic       idle
);
  eng_state_t st;
  byte_kind_t kind;
  logic       rd_go, nack;
  logic [3:0] cnt;
  logic [7:0] sreg, txq, ptr;
  logic       byte_done, load;

  assign byte_done = (st == ST_RX) && scl_fall && (cnt == 4'd8);
  assign wr_en     = byte_done && (kind == K_DATA);
  assign load      = scl_fall && (((st == ST_ACK) && rd_go) || ((st == ST_TXACK) && !nack));
  assign rd_en     = load;
  assign acc_addr  = ptr;
  assign wr_data   = sreg;
  assign sda_oe    = (st == ST_ACK) || ((st == ST_TX) && !txq[7]);
  assign idle      = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      kind  <= K_DEV;
      rd_go <= 1'b0;
      nack  <= 1'b0;
      cnt   <= '0;
      sreg  <= '0;
      txq   <= '0;
      ptr   <= '0;
    end else if (start_det) begin
      st    <= ST_RX;
      kind  <= K_DEV;
      rd_go <= 1'b0;
      cnt   <= '0;
    end else if (stop_det) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise) begin
            sreg <= {sreg[6:0], sda_s};
            cnt  <= cnt + 4'd1;
          end else if (byte_done) begin
            cnt <= '0;
            unique case (kind)
              K_DEV: begin
                if (sreg[7:1] == DEV_ADDR) begin
                  st    <= ST_ACK;
                  rd_go <= sreg[0];
                  kind  <= K_PTR;
                end else begin
                  st <= ST_IDLE;
                end
              end
              K_PTR: begin
                ptr  <= sreg;
                kind <= K_DATA;
                st   <= ST_ACK;
              end
              default: begin
                ptr <= ptr + 8'd1;
                st  <= ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rd_go) begin
              txq <= rd_data;
              ptr <= ptr + 8'd1;
              st  <= ST_TX;
            end else begin
              st <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              st <= ST_TXACK;
            end else begin
              txq <= {txq[6:0], 1'b1};
              cnt <= cnt + 4'd1;
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) nack <= sda_s;
          if (scl_fall) begin
            if (nack) begin
              st <= ST_IDLE;
            end else begin
              txq <= rd_data;
              ptr <= ptr + 8'd1;
              cnt <= '0;
              st  <= ST_TX;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/touch_regfile.sv
module touch_regfile
  import touch_i2c_pkg::*;
#(
  parameter int NKEYS = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [7:0]         addr,
  input  logic [7:0]         wr_data,
  input  logic [7:0]         flags_i,
  input  logic [7:0]         keys_i,
  input  logic [NKEYS*16-1:0] refs_i,
  output logic [7:0]         rd_data,
  output logic               cal_req,
  output logic               rst_req,
  output logic               srst,
  output logic               stat_rd
);
  localparam int NCFG = int'(A_CFGEND) - int'(A_CFG) + 1;

  logic [7:0] cfg [NCFG];
  logic       cal_hit;

  assign cal_hit = wr_en && (addr == A_CAL) && (wr_data != 8'h00);
  assign srst    = wr_en && (addr == A_RST) && (wr_data != 8'h00);
  assign stat_rd = rd_en && ((addr == A_FLAGS) || (addr == A_KEYS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCFG; c++) cfg[c] <= '0;
      cal_req <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      cal_req <= cal_hit;
      rst_req <= srst;
      if (srst) begin
        for (int c = 0; c < NCFG; c++) cfg[c] <= '0;
      end else if (wr_en) begin
        for (int c = 0; c < NCFG; c++)
          if (addr == A_CFG + 8'(c)) cfg[c] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (addr == A_ID)    rd_data = ID_CODE;
    if (addr == A_REV)   rd_data = REV_CODE;
    if (addr == A_FLAGS) rd_data = flags_i;
    if (addr == A_KEYS)  rd_data = keys_i;
    for (int k = 0; k < NKEYS; k++) begin
      if (addr == A_REF + 8'(2*k))     rd_data = refs_i[k*16+8 +: 8];
      if (addr == A_REF + 8'(2*k + 1)) rd_data = refs_i[k*16 +: 8];
    end
    for (int c = 0; c < NCFG; c++)
      if (addr == A_CFG + 8'(c)) rd_data = cfg[c];
  end
endmodule

// File: rtl/chg_notify.sv
module chg_notify #(
  parameter int CHG_DLY = 10_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       clr,
  input  logic [7:0] keys_i,
  output logic       chg_n,
  output logic       done
);
  localparam int CW = $clog2(CHG_DLY + 1);

  logic [CW-1:0] cnt;
  logic [7:0]    key_q;
  logic          pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      done  <= 1'b0;
      pend  <= 1'b0;
      key_q <= '0;
    end else if (restart) begin
      cnt   <= '0;
      done  <= 1'b0;
      pend  <= 1'b0;
      key_q <= keys_i;
    end else begin
      key_q <= keys_i;
      if (!done) begin
        if (cnt == CW'(CHG_DLY - 1)) begin
          done <= 1'b1;
          pend <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (keys_i != key_q) begin
        pend <= 1'b1;
      end else if (clr) begin
        pend <= 1'b0;
      end
    end
  end

  assign chg_n = ~pend;
endmodule

// File: rtl/touch_i2c_regs.sv
module touch_i2c_regs #(
  parameter logic [6:0] DEV_ADDR    = 7'h1B,
  parameter int         NKEYS       = 7,
  parameter int         SYNC_STAGES = 2,
  parameter int         CHG_DLY     = 10_000_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [7:0]         flags_i,
  input  logic [7:0]         keys_i,
  input  logic [NKEYS*16-1:0] refs_i,
  output logic               cal_req_o,
  output logic               rst_req_o,
  output logic               chg_n_o
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       wr_en, rd_en, eng_idle, srst, stat_rd, chg_done;
  logic [7:0] acc_addr, wr_data, rd_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_slave_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_oe(sda_oe_o), .wr_en(wr_en), .rd_en(rd_en),
    .acc_addr(acc_addr), .wr_data(wr_data), .idle(eng_idle)
  );

  touch_regfile #(.NKEYS(NKEYS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(acc_addr),
    .wr_data(wr_data), .flags_i(flags_i), .keys_i(keys_i), .refs_i(refs_i),
    .rd_data(rd_data), .cal_req(cal_req_o), .rst_req(rst_req_o),
    .srst(srst), .stat_rd(stat_rd)
  );

  chg_notify #(.CHG_DLY(CHG_DLY)) u_chg (
    .clk(clk), .rst_n(rst_n), .restart(srst), .clr(stat_rd),
    .keys_i(keys_i), .chg_n(chg_n_o), .done(chg_done)
  );
endmodule

// File: rtl/touch_i2c_regs_chk.sv
module touch_i2c_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       idle,
  input logic       wr_en,
  input logic [7:0] ptr,
  input logic       cal,
  input logic       rst_req,
  input logic       chg_n,
  input logic       chg_done
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe); // R1
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr == $past(ptr) + 8'd1)); // R4
  AST_CAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cal |=> !cal); // R8
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R9
  AST_CHG_EARLY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_done |-> chg_n); // R10
  AST_SDA_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe)); // R11
endmodule

bind touch_i2c_regs touch_i2c_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe_o), .idle(eng_idle),
  .wr_en(wr_en), .ptr(acc_addr), .cal(cal_req_o), .rst_req(rst_req_o),
  .chg_n(chg_n_o), .chg_done(chg_done)
);

// File: tb/touch_i2c_regs_test.sv
module touch_i2c_regs_test;
  localparam int NK  = 7;
  localparam int DLY = 2000;
  localparam int Q   = 8;
  localparam logic [6:0] DA = 7'h1B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;
  logic [7:0] flags = 8'h5A, keys = 8'h00;
  logic [NK*16-1:0] refs;
  logic cal_req, rst_req, chg_n;

  int nchk = 0, nerr = 0, cal_cnt = 0, rst_cnt = 0, viol = 0;
  logic [7:0] exp_q[$], act_q[$];
  string tag_q[$];
  bit fin = 1'b0;

  touch_i2c_regs #(.NKEYS(NK), .SYNC_STAGES(2), .CHG_DLY(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .flags_i(flags), .keys_i(keys), .refs_i(refs), .cal_req_o(cal_req),
    .rst_req_o(rst_req), .chg_n_o(chg_n)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] ref_val(int k);
    return 16'(16'h1000 * (k + 1) + 16'h0011 * (k + 3));
  endfunction

  initial for (int k = 0; k < NK; k++) refs[k*16 +: 16] = ref_val(k);

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus-side monitors
  logic prev_oe = 1'b0, prev_scl = 1'b1;
  always @(negedge clk) begin
    if (cal_req) cal_cnt++;
    if (rst_req) rst_cnt++;
    if (rst_n && scl_m && prev_scl && (sda_oe != prev_oe)) viol++;
    prev_oe  <= sda_oe;
    prev_scl <= scl_m;
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] a, e;
      string t;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(a == e, t, a, e);
    end
  end

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask
  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask
  task automatic wbit(logic b);
    sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
  endtask
  task automatic rbit(output logic b);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); b = sda_bus; qw(); scl_m = 1'b0; qw();
  endtask
  task automatic wr_byte(logic [7:0] d, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(a);
    ack = !a;
  endtask
  task automatic rd_byte(bit ack_it, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(!ack_it);
  endtask

  task automatic expect_byte(logic [7:0] e, string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic write_regs(logic [7:0] p, int n, logic [7:0] d [4]);
    bit ack;
    bus_start();
    wr_byte({DA, 1'b0}, ack); chk(ack, "R2 address ack", ack, 1);
    wr_byte(p, ack);          chk(ack, "R2 pointer ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      wr_byte(d[i], ack);     chk(ack, "R2 data ack", ack, 1);
    end
    bus_stop();
  endtask

  task automatic set_ptr(logic [7:0] p);
    logic [7:0] none [4] = '{8'h0, 8'h0, 8'h0, 8'h0};
    write_regs(p, 0, none);
  endtask

  task automatic read_body(int n);
    logic [7:0] d;
    bit ack;
    wr_byte({DA, 1'b1}, ack); chk(ack, "R3 read header ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i != n - 1, d);
      act_q.push_back(d);
    end
    bus_stop();
    chk(sda_oe == 1'b0, "R5 released after NACK", sda_oe, 0);
  endtask

  task automatic read_regs(int n);
    bus_start();
    read_body(n);
  endtask

  task automatic ptr_then_read(logic [7:0] p, int n);
    bit ack;
    bus_start();
    wr_byte({DA, 1'b0}, ack); chk(ack, "R11 header ack", ack, 1);
    wr_byte(p, ack);          chk(ack, "R11 pointer ack", ack, 1);
    bus_start();
    read_body(n);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      summary();
    end
  end

  initial begin
    bit ack;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(chg_n == 1'b1, "R10 change high after reset", chg_n, 1);
    chk(sda_oe == 1'b0, "R1 SDA released after reset", sda_oe, 0);

    // R1: foreign address is not acknowledged
    bus_start();
    wr_byte({7'h2A, 1'b0}, ack);
    chk(!ack, "R1 foreign address not acked", ack, 0);
    wr_byte(8'h20, ack);
    chk(!ack, "R1 stays silent", ack, 0);
    bus_stop();

    // R2 R7: write three config bytes, read back via stored pointer
    write_regs(8'd32, 3, '{8'h11, 8'h22, 8'h33, 8'h00});
    set_ptr(8'd32);
    expect_byte(8'h11, "R3 read at stored pointer");
    expect_byte(8'h22, "R4 read auto-increment");
    expect_byte(8'h33, "R2 third written byte");
    read_regs(3);
    expect_byte(8'h00, "R3 pointer persisted across STOP");
    expect_byte(8'h00, "R7 config reset value");
    read_regs(2);

    // R10: delay expired, release by reading status
    chk(chg_n == 1'b0, "R10 change low after delay", chg_n, 0);
    expect_byte(8'h5A, "R6 flags byte");
    ptr_then_read(8'd2, 1);
    chk(chg_n == 1'b1, "R10 released by status read", chg_n, 1);
    keys = 8'h04;
    repeat (10) @(negedge clk);
    chk(chg_n == 1'b0, "R10 low on key status change", chg_n, 0);
    set_ptr(8'd3);
    expect_byte(8'h04, "R6 key status byte");
    read_regs(1);
    chk(chg_n == 1'b1, "R10 released by key status read", chg_n, 1);

    // R6: references, ordering, write ignored
    set_ptr(8'd18);
    expect_byte(ref_val(0)[15:8], "R6 key0 ref high");
    expect_byte(ref_val(0)[7:0],  "R6 key0 ref low");
    expect_byte(ref_val(1)[15:8], "R6 key1 ref high");
    expect_byte(ref_val(1)[7:0],  "R6 key1 ref low");
    read_regs(4);
    write_regs(8'd20, 1, '{8'h55, 8'h0, 8'h0, 8'h0});
    write_regs(8'd0, 1, '{8'h99, 8'h0, 8'h0, 8'h0});
    set_ptr(8'd30);
    expect_byte(ref_val(6)[15:8], "R6 key6 ref high");
    expect_byte(ref_val(6)[7:0],  "R6 key6 ref low");
    expect_byte(8'h11,            "R7 first config byte");
    read_regs(3);
    set_ptr(8'd20);
    expect_byte(ref_val(1)[15:8], "R6 read-only write ignored");
    read_regs(1);
    set_ptr(8'd0);
    expect_byte(8'h2E, "R6 id byte after ignored write");
    expect_byte(8'h15, "R6 revision byte");
    read_regs(2);

    // R4: wrap from 255 to 0
    set_ptr(8'd255);
    expect_byte(8'h00, "R4 top address");
    expect_byte(8'h2E, "R4 pointer wrapped to 0");
    read_regs(2);

    // R8: calibration command
    write_regs(8'd56, 1, '{8'h00, 8'h0, 8'h0, 8'h0});
    chk(cal_cnt == 0, "R8 zero write no pulse", cal_cnt, 0);
    write_regs(8'd56, 1, '{8'h01, 8'h0, 8'h0, 8'h0});
    chk(cal_cnt == 1, "R8 nonzero write one pulse", cal_cnt, 1);
    set_ptr(8'd56);
    expect_byte(8'h00, "R8 command reads zero");
    read_regs(1);

    // R9: soft reset command
    write_regs(8'd40, 1, '{8'h77, 8'h0, 8'h0, 8'h0});
    set_ptr(8'd40);
    expect_byte(8'h77, "R7 config write readback");
    read_regs(1);
    keys = 8'h06;
    repeat (10) @(negedge clk);
    write_regs(8'd57, 1, '{8'hA5, 8'h0, 8'h0, 8'h0});
    chk(rst_cnt == 1, "R9 reset pulse", rst_cnt, 1);
    chk(chg_n == 1'b1, "R9 change delay restarted", chg_n, 1);
    set_ptr(8'd40);
    expect_byte(8'h00, "R9 config cleared");
    read_regs(1);
    set_ptr(8'd32);
    expect_byte(8'h00, "R9 first config cleared");
    read_regs(1);

    // R11: no SDA change while SCL high
    chk(viol == 0, "R11 SDA stable while SCL high", viol, 0);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected bytes received", exp_q.size(), 0);
    fin = 1'b1;
    summary();
  end
endmodule